// File: doc/BRIEF.md
# Key-Gated DMA Register Unit

This block is the register front end of a flash controller's DMA engine. A single 32-bit write port reaches four registers: a control word, a DRAM address, a flash address and a transfer length. Software cannot program the engine whenever it likes. It must first open access by writing a key value to the control register. It then loads the address and length registers, and finally issues a control write that launches the transfer. That launch consumes the access, so every new transfer needs a new key.

The control register keeps two status flags in its top bits: bit 31 shows that access was requested, and bit 30 shows that it was granted. On every control write, these two flags are ORed into the incoming word before it is compared with the keys. A second key closes access without launching anything. The outputs are a one-cycle launch pulse, a one-cycle error pulse for refused control writes, the grant state, and the latched parameters for the data mover. A build parameter removes the gate entirely. In that build every write is honoured and the key values are ordinary data.

Top module: `fdma_keyreg`

## Requirements
- R1: After reset every register reads 0, `access_ok` is 0 (gated build), and `dma_go` and `gate_err` are 0.
- R2: A write to control (byte offset 0x80) whose value ORed with the current flags (bit 31 request, bit 30 grant) equals 0xAEED0000 sets both flags. It leaves bits 29:0 unchanged and raises neither pulse.
- R3: A control write whose merged value equals 0xDEEA0000 clears both flags, whether or not access was open. It changes nothing else and raises no error.
- R4: Any other control write while grant is 0 is discarded, and `gate_err` is 1 for exactly the next cycle.
- R5: A control write that is not a key, made while grant is 1, stores bits 29:0 and clears both flags. Because of the merge, writing 0xAEED0000 while access is open falls into this case.
- R6: `dma_go` pulses for one cycle after an R5 write whose bit 0 is 1. With bit 0 at 0, the word is only stored.
- R7: Writes to DRAM address (0x84), flash address (0x88) and length (0x8C) take effect only while grant is 1. Otherwise they are ignored.
- R8: Stored parameters are masked: DRAM address with 0x3FFFFFFC, flash address with 0x0FFFFFFC, length with 0x00FFFFFC.
- R9: `rd_data` returns the register at `rd_addr`. Control reads as {request, grant, bits 29:0}, and an unmapped offset reads 0.
- R10: `delay_sel` equals stored control bits 11:8.
- R11: With `GATE_EN`=0, `access_ok` is always 1, key values are stored as ordinary control words, and parameter writes always land.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Write byte offset |
| wr_data | input | 32 | Write value |
| rd_addr | input | AW | Read byte offset |
| rd_data | output | 32 | Read value (combinational) |
| dma_go | output | 1 | One-cycle transfer launch |
| gate_err | output | 1 | One-cycle refused-write flag |
| access_ok | output | 1 | Access currently granted |
| delay_sel | output | 4 | Control delay field |
| cmd_bits | output | 30 | Stored control bits 29:0 |
| dram_addr | output | 32 | Latched DRAM address |
| flash_addr | output | 32 | Latched flash address |
| xfer_len | output | 32 | Latched transfer length |

## Verification
Every effect of a write is registered at the clock edge that samples the strobe. Stored values, the flags, `dma_go` and `gate_err` are therefore all due one cycle after the write is presented, and the two pulses fall again one cycle later. `rd_data` is combinational on stored state, so it is due in that same cycle. The driver tags each expected item with the cycle it is due. The monitor pops items only at the falling edge of that cycle, and it sets the read offset before it samples. This keeps every comparison half a period away from the active edge.

// File: rtl/fdma_keyreg_pkg.sv
package fdma_keyreg_pkg;

    localparam int DW = 32;

    // register byte offsets
    localparam logic [7:0] OFS_CTRL  = 8'h80;
    localparam logic [7:0] OFS_DRAM  = 8'h84;
    localparam logic [7:0] OFS_FLASH = 8'h88;
    localparam logic [7:0] OFS_LEN   = 8'h8C;

    // control word fields
    localparam int REQ_BIT = 31;
    localparam int GNT_BIT = 30;
    localparam int GO_BIT  = 0;
    localparam int DLY_LSB = 8;
    localparam int DLY_W   = 4;
    localparam int BODY_W  = 30;

    // access keys (compared after the flags are merged in)
    localparam logic [DW-1:0] KEY_OPEN = 32'hAEED_0000;
    localparam logic [DW-1:0] KEY_SHUT = 32'hDEEA_0000;

    // parameter register slots
    localparam int NPAR    = 3;
    localparam int P_DRAM  = 0;
    localparam int P_FLASH = 1;
    localparam int P_LEN   = 2;

    typedef enum logic [1:0] {
        CW_OPEN,
        CW_SHUT,
        CW_DENY,
        CW_TAKE
    } ctrl_cmd_e;

    typedef struct packed {
        logic              req;
        logic              gnt;
        logic [BODY_W-1:0] body;
    } ctrl_reg_t;

    function automatic logic [7:0] par_ofs(input int idx);
        case (idx)
            P_DRAM:  return OFS_DRAM;
            P_FLASH: return OFS_FLASH;
            default: return OFS_LEN;
        endcase
    endfunction

endpackage

// File: rtl/fdma_key_decode.sv
module fdma_key_decode
    import fdma_keyreg_pkg::*;
#(
    parameter bit GATE_EN = 1'b1
) (
    input  logic [DW-1:0] wdata,
    input  logic          req,
    input  logic          gnt,
    output ctrl_cmd_e     cmd,
    output logic [DW-1:0] merged
);

    always_comb begin
        merged          = wdata;
        merged[REQ_BIT] = wdata[REQ_BIT] | req;
        merged[GNT_BIT] = wdata[GNT_BIT] | gnt;
    end

    generate
        if (GATE_EN) begin : g_gated
            always_comb begin
                if (merged == KEY_OPEN)      cmd = CW_OPEN;
                else if (merged == KEY_SHUT) cmd = CW_SHUT;
                else if (!gnt)               cmd = CW_DENY;
                else                         cmd = CW_TAKE;
            end
        end else begin : g_open
            assign cmd = CW_TAKE;
        end
    endgenerate

endmodule

// File: rtl/fdma_ctrl_reg.sv
module fdma_ctrl_reg
    import fdma_keyreg_pkg::*;
#(
    parameter bit GATE_EN = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_ctrl,
    input  logic [DW-1:0] wdata,
    output ctrl_reg_t     cur,
    output logic          granted,
    output logic          start,
    output logic          deny_err
);

    ctrl_cmd_e     cmd;
    logic [DW-1:0] merged;

    fdma_key_decode #(.GATE_EN(GATE_EN)) u_dec (
        .wdata  (wdata),
        .req    (cur.req),
        .gnt    (cur.gnt),
        .cmd    (cmd),
        .merged (merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur      <= '0;
            start    <= 1'b0;
            deny_err <= 1'b0;
        end else begin
            start    <= 1'b0;
            deny_err <= 1'b0;
            if (wr_ctrl) begin
                case (cmd)
                    CW_OPEN: begin
                        cur.req <= 1'b1;
                        cur.gnt <= 1'b1;
                    end
                    CW_SHUT: begin
                        cur.req <= 1'b0;
                        cur.gnt <= 1'b0;
                    end
                    CW_DENY: deny_err <= 1'b1;
                    default: begin
                        cur.body <= merged[BODY_W-1:0];
                        cur.req  <= 1'b0;
                        cur.gnt  <= 1'b0;
                        start    <= merged[GO_BIT];
                    end
                endcase
            end
        end
    end

    assign granted = GATE_EN ? cur.gnt : 1'b1;

    // both flags always move together
    p_flag_pair_r2: assert property (@(posedge clk) disable iff (rst)
        cur.req == cur.gnt);

    p_open_sets_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && cmd == CW_OPEN) |=> (cur.gnt && $stable(cur.body) && !start && !deny_err));

    p_shut_clears_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && cmd == CW_SHUT) |=> (!cur.gnt && !cur.req && $stable(cur.body) && !deny_err));

    p_deny_flags_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && cmd == CW_DENY) |=> (deny_err && !start && $stable(cur.body)));

    p_take_consumes_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && cmd == CW_TAKE) |=> (!cur.gnt && !deny_err));

    p_go_one_cycle_r6: assert property (@(posedge clk) disable iff (rst)
        (GATE_EN && start) |=> !start);

endmodule

// File: rtl/fdma_param_regs.sv
module fdma_param_regs
    import fdma_keyreg_pkg::*;
#(
    parameter int                        N     = NPAR,
    parameter logic [N-1:0][DW-1:0]      MASKS = '0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [N-1:0]          hit,
    input  logic                  allow,
    input  logic [DW-1:0]         wdata,
    output logic [N-1:0][DW-1:0]  q
);

    generate
        for (genvar i = 0; i < N; i++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst)                 q[i] <= '0;
                else if (hit[i] && allow) q[i] <= wdata & MASKS[i];
            end
        end
    endgenerate

    // closed access leaves every parameter untouched
    p_locked_r7: assert property (@(posedge clk) disable iff (rst)
        !allow |=> $stable(q));

    p_one_hit_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit));

endmodule

// File: rtl/fdma_keyreg.sv
module fdma_keyreg
    import fdma_keyreg_pkg::*;
#(
    parameter bit          GATE_EN    = 1'b1,
    parameter int          AW         = 8,
    parameter logic [31:0] DRAM_MASK  = 32'h3FFF_FFFC,
    parameter logic [31:0] FLASH_MASK = 32'h0FFF_FFFC,
    parameter logic [31:0] LEN_MASK   = 32'h00FF_FFFC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DW-1:0]     rd_data,
    output logic              dma_go,
    output logic              gate_err,
    output logic              access_ok,
    output logic [DLY_W-1:0]  delay_sel,
    output logic [BODY_W-1:0] cmd_bits,
    output logic [DW-1:0]     dram_addr,
    output logic [DW-1:0]     flash_addr,
    output logic [DW-1:0]     xfer_len
);

    localparam logic [NPAR-1:0][DW-1:0] PAR_MASKS = {LEN_MASK, FLASH_MASK, DRAM_MASK};

    ctrl_reg_t                  cur;
    logic                       wr_ctrl;
    logic [NPAR-1:0]            par_hit;
    logic [NPAR-1:0][DW-1:0]    par_q;

    assign wr_ctrl = wr_en && (wr_addr == AW'(OFS_CTRL));

    always_comb begin
        for (int i = 0; i < NPAR; i++) begin
            par_hit[i] = wr_en && (wr_addr == AW'(par_ofs(i)));
        end
    end

    fdma_ctrl_reg #(.GATE_EN(GATE_EN)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_ctrl  (wr_ctrl),
        .wdata    (wr_data),
        .cur      (cur),
        .granted  (access_ok),
        .start    (dma_go),
        .deny_err (gate_err)
    );

    fdma_param_regs #(.N(NPAR), .MASKS(PAR_MASKS)) u_par (
        .clk   (clk),
        .rst   (rst),
        .hit   (par_hit),
        .allow (access_ok),
        .wdata (wr_data),
        .q     (par_q)
    );

    always_comb begin
        rd_data = '0;
        if (rd_addr == AW'(OFS_CTRL)) rd_data = cur;
        for (int i = 0; i < NPAR; i++) begin
            if (rd_addr == AW'(par_ofs(i))) rd_data = par_q[i];
        end
    end

    assign cmd_bits   = cur.body;
    assign delay_sel  = cur.body[DLY_LSB +: DLY_W];
    assign dram_addr  = par_q[P_DRAM];
    assign flash_addr = par_q[P_FLASH];
    assign xfer_len   = par_q[P_LEN];

    p_err_excludes_go_r4: assert property (@(posedge clk) disable iff (rst)
        !(gate_err && dma_go));

endmodule

// File: tb/fdma_keyreg_tb_top.sv
module fdma_keyreg_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0, rd_addr2 = '0;
    logic [31:0] rd_data, rd_data2;
    logic        dma_go, gate_err, access_ok, go2, err2, ok2;
    logic [3:0]  delay_sel, dly2;
    logic [29:0] cmd_bits, cb2;
    logic [31:0] dram_addr, flash_addr, xfer_len, da2, fa2, xl2;

    int cyc = 0;
    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct {
        int          due;
        int          kind;
        logic [7:0]  addr;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    localparam int K_RD = 0, K_GO = 1, K_ERR = 2, K_OK = 3, K_DLY = 4,
                   K_RD2 = 5, K_GO2 = 6, K_OK2 = 7, K_DRAM = 8;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fdma_keyreg dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .dma_go(dma_go), .gate_err(gate_err),
        .access_ok(access_ok), .delay_sel(delay_sel), .cmd_bits(cmd_bits),
        .dram_addr(dram_addr), .flash_addr(flash_addr), .xfer_len(xfer_len)
    );

    fdma_keyreg #(.GATE_EN(1'b0)) dut_open (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr2), .rd_data(rd_data2), .dma_go(go2), .gate_err(err2),
        .access_ok(ok2), .delay_sel(dly2), .cmd_bits(cb2),
        .dram_addr(da2), .flash_addr(fa2), .xfer_len(xl2)
    );

    // driver helpers
    task automatic expect_item(int kind, logic [7:0] addr, logic [31:0] exp, string tag);
        item_t it;
        it.due = cyc + 1; it.kind = kind; it.addr = addr; it.exp = exp; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic put(logic [7:0] a, logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
    endtask

    task automatic step();
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // monitor: compares items in the cycle they are due
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0 && sb[0].due == cyc) begin
                item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                if (it.kind == K_RD)  rd_addr  = it.addr;
                if (it.kind == K_RD2) rd_addr2 = it.addr;
                #1;
                case (it.kind)
                    K_RD:    act = rd_data;
                    K_GO:    act = {31'b0, dma_go};
                    K_ERR:   act = {31'b0, gate_err};
                    K_OK:    act = {31'b0, access_ok};
                    K_DLY:   act = {28'b0, delay_sel};
                    K_RD2:   act = rd_data2;
                    K_GO2:   act = {31'b0, go2};
                    K_OK2:   act = {31'b0, ok2};
                    default: act = dram_addr;
                endcase
                total++;
                if (act !== it.exp) begin
                    bad++;
                    $display("FAIL %s kind=%0d addr=%h actual=%h expected=%h",
                             it.tag, it.kind, it.addr, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        expect_item(K_RD, 8'h80, 32'h0, "R1");
        expect_item(K_RD, 8'h84, 32'h0, "R1");
        expect_item(K_OK, 0, 32'h0, "R1");
        expect_item(K_GO, 0, 32'h0, "R1");
        expect_item(K_ERR, 0, 32'h0, "R1");
        step();
        // R7 parameter write while closed
        put(8'h84, 32'h1234_5678);
        expect_item(K_RD, 8'h84, 32'h0, "R7");
        step();
        // R4 refused control write
        put(8'h80, 32'h0000_0301);
        expect_item(K_ERR, 0, 32'h1, "R4");
        expect_item(K_GO, 0, 32'h0, "R4");
        expect_item(K_RD, 8'h80, 32'h0, "R4");
        step();
        expect_item(K_ERR, 0, 32'h0, "R4");
        step();
        // R2 open key
        put(8'h80, 32'hAEED_0000);
        expect_item(K_OK, 0, 32'h1, "R2");
        expect_item(K_RD, 8'h80, 32'hC000_0000, "R2");
        expect_item(K_ERR, 0, 32'h0, "R2");
        expect_item(K_GO, 0, 32'h0, "R2");
        step();
        // R8 masked parameters
        put(8'h84, 32'hFFFF_FFFF);
        expect_item(K_RD, 8'h84, 32'h3FFF_FFFC, "R8");
        expect_item(K_DRAM, 0, 32'h3FFF_FFFC, "R8");
        step();
        put(8'h88, 32'hFFFF_FFFF);
        expect_item(K_RD, 8'h88, 32'h0FFF_FFFC, "R8");
        step();
        put(8'h8C, 32'h1234_5677);
        expect_item(K_RD, 8'h8C, 32'h0034_5674, "R8");
        expect_item(K_OK, 0, 32'h1, "R7");
        step();
        // R5 R6 R10 launch
        put(8'h80, 32'h0000_0A01);
        expect_item(K_GO, 0, 32'h1, "R6");
        expect_item(K_OK, 0, 32'h0, "R5");
        expect_item(K_RD, 8'h80, 32'h0000_0A01, "R5");
        expect_item(K_DLY, 0, 32'hA, "R10");
        step();
        expect_item(K_GO, 0, 32'h0, "R6");
        step();
        // R7 grant consumed: write ignored
        put(8'h84, 32'h1111_1111);
        expect_item(K_RD, 8'h84, 32'h3FFF_FFFC, "R7");
        step();
        // R3 shut while open
        put(8'h80, 32'hAEED_0000);
        step();
        put(8'h80, 32'hDEEA_0000);
        expect_item(K_OK, 0, 32'h0, "R3");
        expect_item(K_RD, 8'h80, 32'h0000_0A01, "R3");
        step();
        // R3 shut while closed: no error
        put(8'h80, 32'hDEEA_0000);
        expect_item(K_ERR, 0, 32'h0, "R3");
        expect_item(K_RD, 8'h80, 32'h0000_0A01, "R3");
        step();
        // R6 store without launch
        put(8'h80, 32'hAEED_0000);
        step();
        put(8'h80, 32'h0000_0500);
        expect_item(K_GO, 0, 32'h0, "R6");
        expect_item(K_RD, 8'h80, 32'h0000_0500, "R6");
        step();
        // R5 open key while open is a plain write
        put(8'h80, 32'hAEED_0000);
        step();
        put(8'h80, 32'hAEED_0000);
        expect_item(K_RD, 8'h80, 32'h2EED_0000, "R5");
        expect_item(K_OK, 0, 32'h0, "R5");
        expect_item(K_GO, 0, 32'h0, "R5");
        step();
        // R4 near-key values while closed
        put(8'h80, 32'h6EED_0000);
        expect_item(K_ERR, 0, 32'h1, "R4");
        expect_item(K_OK, 0, 32'h0, "R4");
        step();
        put(8'h80, 32'h1EEA_0000);
        expect_item(K_ERR, 0, 32'h1, "R4");
        expect_item(K_RD, 8'h80, 32'h2EED_0000, "R4");
        step();
        // R9 unmapped read
        expect_item(K_RD, 8'h90, 32'h0, "R9");
        expect_item(K_RD, 8'h7C, 32'h0, "R9");
        step();
        // R11 ungated build
        put(8'h84, 32'h0000_1237);
        expect_item(K_RD2, 8'h84, 32'h0000_1234, "R11");
        expect_item(K_OK2, 0, 32'h1, "R11");
        step();
        put(8'h80, 32'hAEED_0000);
        expect_item(K_RD2, 8'h80, 32'h2EED_0000, "R11");
        expect_item(K_GO2, 0, 32'h0, "R11");
        expect_item(K_OK2, 0, 32'h1, "R11");
        step();
        put(8'h80, 32'h0000_0001);
        expect_item(K_GO2, 0, 32'h1, "R11");
        step();
        put(8'h80, 32'h0000_0001);
        expect_item(K_GO2, 0, 32'h1, "R11");
        step();
        repeat (3) step();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule